// File: doc/BRIEF.md
# Clock-Stop SPI Master Port

This block is a serial port that acts as an SPI master whose bit clock runs only while a word is in flight. A one-cycle start strobe hands it a parallel word and a run-time divider value. The port pulls its active-low select down, presents the top bit of the word, and toggles the bit clock for exactly one word. Outgoing bits move on rising clock edges and incoming bits are captured on falling edges, most significant bit first. Between words the clock rests low and the data driver is released.

The divider sets the bit period in system clock cycles. The split between the low and high phases depends on whether the divider value is even or odd. The select lead before the first rising edge equals one low phase. The select trail after the last falling edge equals one full period. At the end of the trail the port raises select, pulses done for one cycle and presents the received word. A busy flag covers the whole transfer, and start requests that arrive during it are dropped.

Top module: `cs_spi_master`

## Requirements
- R1: While rst_ni is low, cs_no_o is 1, sclk_o is 0, mosi_oe_o is 0, busy_o is 0 and done_o is 0.
- R2: With divider value D (D = 0 is treated as 1), successive rising edges of sclk_o are exactly D+1 system cycles apart.
- R3: The low phase lasts L = D/2 cycles when D is even and (D+1)/2 cycles when D is odd. The high phase lasts (D+1) - L cycles.
- R4: sclk_o is 0 and does not toggle whenever cs_no_o is 1.
- R5: cs_no_o falls exactly L cycles before the first rising edge of sclk_o.
- R6: mosi_o carries tx_data_i MSB first. The MSB is valid in the cycle cs_no_o falls, and mosi_o changes only in cycles where sclk_o rises.
- R7: miso_i is sampled at each falling edge of sclk_o, MSB first. The assembled word is on rx_data_o when done_o pulses.
- R8: cs_no_o rises exactly D+1 cycles after the last falling edge of sclk_o. done_o is high for exactly that one cycle.
- R9: mosi_oe_o is 0 whenever cs_no_o is 1, and it drops before cs_no_o rises, after the last bit.
- R10: div_i and tx_data_i are captured on the start cycle. Later changes to them do not affect the transfer in progress.
- R11: busy_o is 1 from the cycle after start_i until done_o. A start_i pulse while busy_o is 1 starts no transfer.
- R12: Each transfer has exactly WORD_W rising edges of sclk_o (WORD_W from 8 to 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle transfer request |
| div_i | input | DIV_W | Bit-clock divider value D |
| tx_data_i | input | WORD_W | Word to send |
| miso_i | input | 1 | Serial data from slave |
| sclk_o | output | 1 | Bit clock, idles low |
| cs_no_o | output | 1 | Active-low slave select |
| mosi_o | output | 1 | Serial data to slave |
| mosi_oe_o | output | 1 | Driver enable for mosi_o (0 = high impedance) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rx_data_o | output | WORD_W | Last received word |

## Verification
The hardest cases to reach are the phase-length extremes and the interference cases. The extremes are divider 0, which is clamped, divider 1, where each phase is a single cycle, and dividers 254 and 255, where the long low phase flips between even and odd rounding. The interference cases are a new start strobe and a changed divider arriving in the middle of a word. The driver sequences transfers over these divider values. On selected words it rewrites div_i right after the start and fires a second start a few cycles in. A bench-side slave model answers each word with its own pattern, and the monitor measures every phase length and edge position against values computed from the divider that was latched.

// File: rtl/cs_spi_pkg.sv
package cs_spi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL
  } state_e;
endpackage

// File: rtl/cs_spi_timer.sv
// Latches the divider at start and derives the low/high phase lengths.
module cs_spi_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] low_len_o,
  output logic [DIV_W-1:0] high_len_o
);
  logic [DIV_W-1:0] div_q, div_sel, div_eff, low_len;
  logic [DIV_W:0]   period, high_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (latch_i) div_q <= div_i;
  end

  // live value on the start cycle, latched value afterwards
  assign div_sel = latch_i ? div_i : div_q;
  assign div_eff = (div_sel == '0) ? DIV_W'(1) : div_sel;

  // odd: half period, even: D/2
  assign low_len = (div_eff >> 1) + {{(DIV_W-1){1'b0}}, div_eff[0]};
  assign period  = {1'b0, div_eff} + {{DIV_W{1'b0}}, 1'b1};
  assign high_w  = period - {1'b0, low_len};

  assign low_len_o  = low_len;
  assign high_len_o = high_w[DIV_W-1:0];
endmodule

// File: rtl/cs_spi_shift.sv
// Transmit and receive shift registers plus the received-word holding register.
module cs_spi_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_shift_i,
  input  logic              rx_sample_i,
  input  logic              miso_i,
  input  logic              finish_i,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_data_o
);
  logic [WORD_W-1:0] tx_q, rx_q, rx_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tx_q <= '0;
    else if (load_i)     tx_q <= tx_data_i;
    else if (tx_shift_i) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rx_q <= '0;
    else if (load_i)      rx_q <= '0;
    else if (rx_sample_i) rx_q <= {rx_q[WORD_W-2:0], miso_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_hold_q <= '0;
    else if (finish_i) rx_hold_q <= rx_q;
  end

  assign mosi_o    = tx_q[WORD_W-1];
  assign rx_data_o = rx_hold_q;
endmodule

// File: rtl/cs_spi_fsm.sv
// Phase sequencer: lead, WORD_W x (high, low), tail.
module cs_spi_fsm #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] low_len_i,
  input  logic [DIV_W-1:0] high_len_i,
  output logic             load_o,
  output logic             tx_shift_o,
  output logic             rx_sample_o,
  output logic             finish_o,
  output logic             sclk_o,
  output logic             cs_no_o,
  output logic             mosi_oe_o,
  output logic             busy_o,
  output logic             done_o
);
  import cs_spi_pkg::*;

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  state_e           state_q;
  logic [DIV_W-1:0] cnt_q;
  logic [BIT_W-1:0] bit_q;
  logic             done_q;
  logic             phase_end, last_bit;

  assign phase_end = (cnt_q == '0);
  assign last_bit  = (bit_q == LAST_BIT);

  assign load_o      = (state_q == ST_IDLE) && start_i;
  assign rx_sample_o = (state_q == ST_HIGH) && phase_end;
  assign tx_shift_o  = (state_q == ST_LOW) && phase_end && !last_bit;
  assign finish_o    = (state_q == ST_TAIL) && phase_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish_o;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_LEAD;
            cnt_q   <= low_len_i - 1'b1;
            bit_q   <= '0;
          end
        end
        ST_LEAD: begin
          if (phase_end) begin
            state_q <= ST_HIGH;
            cnt_q   <= high_len_i - 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_HIGH: begin
          if (phase_end) begin
            state_q <= ST_LOW;
            cnt_q   <= low_len_i - 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_LOW: begin
          if (phase_end) begin
            cnt_q <= high_len_i - 1'b1;
            if (last_bit) state_q <= ST_TAIL;
            else begin
              state_q <= ST_HIGH;
              bit_q   <= bit_q + 1'b1;
            end
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_TAIL: begin
          if (phase_end) state_q <= ST_IDLE;
          else           cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o    = (state_q == ST_HIGH);
  assign cs_no_o   = (state_q == ST_IDLE);
  assign mosi_oe_o = (state_q == ST_LEAD) || (state_q == ST_HIGH) || (state_q == ST_LOW);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
endmodule

// File: rtl/cs_spi_master.sv
module cs_spi_master #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              cs_no_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_data_o
);
  logic             load, tx_shift, rx_sample, finish;
  logic [DIV_W-1:0] low_len, high_len;

  cs_spi_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .latch_i    (load),
    .div_i      (div_i),
    .low_len_o  (low_len),
    .high_len_o (high_len)
  );

  cs_spi_fsm #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .low_len_i   (low_len),
    .high_len_i  (high_len),
    .load_o      (load),
    .tx_shift_o  (tx_shift),
    .rx_sample_o (rx_sample),
    .finish_o    (finish),
    .sclk_o      (sclk_o),
    .cs_no_o     (cs_no_o),
    .mosi_oe_o   (mosi_oe_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  cs_spi_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .tx_data_i   (tx_data_i),
    .tx_shift_i  (tx_shift),
    .rx_sample_i (rx_sample),
    .miso_i      (miso_i),
    .finish_i    (finish),
    .mosi_o      (mosi_o),
    .rx_data_o   (rx_data_o)
  );
endmodule

// File: rtl/cs_spi_master_chk.sv
module cs_spi_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic sclk_o,
  input logic cs_no_o,
  input logic mosi_o,
  input logic mosi_oe_o,
  input logic busy_o,
  input logic done_o
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no_o |-> !sclk_o); // R4
  AST_MOSI_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mosi_oe_o && $past(mosi_oe_o) && !$rose(sclk_o)) |-> $stable(mosi_o)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_WITH_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no_o && !$past(cs_no_o))); // R8
  AST_OE_RELEASED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no_o |-> !mosi_oe_o); // R9
  AST_BUSY_COVERS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no_o |-> busy_o); // R11
  AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R11
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !$fell(cs_no_o)); // R11
endmodule

bind cs_spi_master cs_spi_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .sclk_o    (sclk_o),
  .cs_no_o   (cs_no_o),
  .mosi_o    (mosi_o),
  .mosi_oe_o (mosi_oe_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/tb_cs_spi_master.sv
module tb_cs_spi_master;
  localparam int W  = 16;
  localparam int DW = 8;

  typedef struct {
    int          div;
    logic [W-1:0] tx;
    logic [W-1:0] sw;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [DW-1:0] div_i = '0;
  logic [W-1:0]  tx_data_i = '0;
  logic          miso = 1'b0;
  logic          sclk, cs_n, mosi, mosi_oe, busy, done;
  logic [W-1:0]  rx_data;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  logic [W-1:0] slave_word = '0;
  int r4_bad = 0;

  always #2 clk = ~clk;

  cs_spi_master #(.WORD_W(W), .DIV_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .div_i(div_i),
    .tx_data_i(tx_data_i), .miso_i(miso), .sclk_o(sclk), .cs_no_o(cs_n),
    .mosi_o(mosi), .mosi_oe_o(mosi_oe), .busy_o(busy), .done_o(done),
    .rx_data_o(rx_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction
  function automatic int low_len(input int d);
    return (eff(d) % 2 == 1) ? (eff(d) + 1) / 2 : eff(d) / 2;
  endfunction
  function automatic int high_len(input int d);
    return eff(d) + 1 - low_len(d);
  endfunction

  // monitor + slave model + scoreboard
  int cyc = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;
  int t_csfall, t_lastrise, t_lastfall, t_firstrise, rises, bad_hi, bad_lo, sidx;
  int bad_mosi, lead;
  logic [W-1:0] mosi_word;
  bit first_ok;

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (cs_n && sclk) r4_bad++;
      if (prev_cs && !cs_n) begin
        t_csfall = cyc; rises = 0; bad_hi = 0; bad_lo = 0; bad_mosi = 0;
        mosi_word = '0;
        first_ok = mosi_oe && (mosi == q[0].tx[W-1]);
        sidx = W - 1; miso = slave_word[W-1];
      end
      if (!cs_n && !prev_cs && mosi != prev_mosi && !(sclk && !prev_sclk)) bad_mosi++;
      if (!cs_n && sclk && !prev_sclk) begin
        if (rises == 0) begin
          lead = cyc - t_csfall; t_firstrise = cyc;
        end else begin
          if (cyc - t_lastfall != low_len(q[0].div)) bad_lo++;
          if (sidx > 0) sidx--;
          miso = slave_word[sidx];
        end
        t_lastrise = cyc; rises++;
      end
      if (!sclk && prev_sclk) begin
        if (cyc - t_lastrise != high_len(q[0].div)) bad_hi++;
        mosi_word = {mosi_word[W-2:0], mosi};
        t_lastfall = cyc;
      end
      if (!prev_cs && cs_n) begin
        if (q.size() == 0) chk(0, "R11", "unexpected transfer", 1, 0);
        else begin
          exp_t e;
          int p;
          e = q.pop_front();
          p = eff(e.div) + 1;
          chk(first_ok, "R6", "MSB at select fall", first_ok, 1);
          chk(lead == low_len(e.div), "R5", "lead", lead, low_len(e.div));
          chk(bad_hi == 0 && bad_lo == 0, "R3", "phase widths bad count", bad_hi + bad_lo, 0);
          chk(t_lastrise - t_firstrise == (W - 1) * p, "R2", "rise span",
              t_lastrise - t_firstrise, (W - 1) * p);
          chk(rises == W, "R12", "rising edges", rises, W);
          chk(mosi_word == e.tx && bad_mosi == 0, "R6", "mosi word", mosi_word, e.tx);
          chk(rx_data == e.sw, "R7", "rx word", rx_data, e.sw);
          chk(cyc - t_lastfall == p, "R8", "tail", cyc - t_lastfall, p);
          chk(done == 1'b1, "R8", "done at select rise", done, 1);
          chk(mosi_oe == 1'b0, "R9", "oe after last bit", mosi_oe, 0);
          chk(e.div != 255 || (rx_data == e.sw), "R10", "latched div transfer ok", rx_data, e.sw);
        end
      end
      prev_cs = cs_n; prev_sclk = sclk; prev_mosi = mosi;
    end
  end

  task automatic do_xfer(input int d, input logic [W-1:0] tx, input logic [W-1:0] sw,
                         input bit disturb);
    int stray;
    exp_t e;
    e.div = d; e.tx = tx; e.sw = sw;
    @(negedge clk);
    q.push_back(e);
    slave_word = sw;
    start_i = 1'b1; div_i = DW'(d); tx_data_i = tx;
    @(negedge clk);
    start_i = 1'b0; div_i = ~DW'(d); tx_data_i = ~tx;  // R10: inputs change mid-transfer
    chk(busy == 1'b1, "R11", "busy after start", busy, 1);
    if (disturb) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1; tx_data_i = '1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done) @(negedge clk);
    stray = 0;
    repeat (12) begin
      @(negedge clk);
      if (!cs_n || busy || sclk) stray++;
    end
    chk(stray == 0, "R11", "no transfer after done", stray, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && mosi_oe == 0 && busy == 0 && done == 0,
        "R1", "reset outputs", {cs_n, sclk, mosi_oe, busy, done}, 5'b10000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    do_xfer(1,   16'hA55A, 16'h3C96, 0);
    do_xfer(0,   16'h1234, 16'hFEDC, 0);
    do_xfer(2,   16'h8001, 16'h7FFE, 0);
    do_xfer(3,   16'hF00F, 16'h0FF0, 1);
    do_xfer(4,   16'hC3A5, 16'h5A3C, 0);
    do_xfer(7,   16'h0001, 16'h8000, 1);
    do_xfer(255, 16'h6B2D, 16'hD2B6, 0);
    do_xfer(254, 16'h9E71, 16'h178E, 1);
    chk(r4_bad == 0, "R4", "sclk high while deselected", r4_bad, 0);
    chk(q.size() == 0, "R11", "pending expectations", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule